// File: doc/BRIEF.md
# Shared-Pin General-Purpose I/O Port

This block manages a small port of pins, six by default. Each pin is either handed to a serial peripheral or used as a general-purpose input or output. Three registers control the port: an ownership register, a direction register and a data register. All three sit on a simple memory-mapped register bus with a 24-bit data path.

For every pin the block selects the pad output value and output enable. It takes them either from the peripheral's per-pin signals or from the general-purpose registers. It also samples the pad level through a synchronizer so that software can read it.

One ownership bit per pin decides who drives the pin. A set bit hands the pin to the peripheral, and the direction bit then has no effect. A clear bit makes the pin general-purpose, and the direction bit chooses between input and output.

Two reset sources exist:
- An asynchronous hardware reset clears all three registers.
- A one-cycle synchronous software-reset pulse also clears all three registers.

The register base address is a parameter, so several ports can share one bus at different addresses.

Top module: `shared_gpio_port`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, and without waiting for a clock edge, the ownership, direction and data registers are 0 and `pad_oe` is all zero. Every pin therefore starts as a general-purpose input.
- R2: When `soft_rst` is high at a rising clock edge, the ownership, direction and data registers are all 0 after that edge, and `pad_oe` is all zero.
- R3: For a pin whose ownership bit is 1, `pad_out` and `pad_oe` equal that pin's `per_out` and `per_oe`, whatever its direction bit holds.
- R4: For a pin with ownership 0 and direction 1, `pad_oe` is 1, `pad_out` equals the stored data bit, and reading the data register returns the stored bit.
- R5: For a pin with ownership 0 and direction 0, `pad_oe` is 0. A data register read returns the pad level as it stood two rising clock edges earlier, through a two-flop synchronizer. A change seen at only one edge is not yet visible.
- R6: Reading the data register returns 0 in every bit position whose pin is owned by the peripheral.
- R7: In every register, bits 23 down to the pin count (23:6 by default) read as 0, and written values in those bits are dropped.
- R8: A write to the data register stores the bit for every pin, whatever its mode. The stored value is driven once the pin becomes a general-purpose output.
- R9: Register addresses are BASE_ADDR+0 for ownership, +1 for direction and +2 for data. A write with `bus_wr` high takes effect at the next rising edge and not before. Registers hold their value without a write. Reads of any other address return 0, and writes to any other address change nothing.
- R10: `per_in` always carries the current `pad_in` levels to the peripheral, without delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and synchronizer clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software-reset pulse, active high |
| bus_addr | input | ADDR_W (8) | Register bus address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | BUS_W (24) | Register write data |
| bus_rdata | output | BUS_W (24) | Combinational read data for `bus_addr` |
| per_out | input | NUM_PINS (6) | Peripheral output value per pin |
| per_oe | input | NUM_PINS (6) | Peripheral output enable per pin |
| per_in | output | NUM_PINS (6) | Pad levels passed to the peripheral |
| pad_in | input | NUM_PINS (6) | Level sensed at each pad |
| pad_out | output | NUM_PINS (6) | Value driven to each pad |
| pad_oe | output | NUM_PINS (6) | Output enable of each pad |

## Verification
Ownership and direction bits feed `pad_oe` and `pad_out` combinationally. A corrupted configuration bit therefore shows at the pad outputs in the same cycle the register changes. The bench checks the pad outputs right after each write and reset.

A wrong stored data bit can stay hidden while its pin is an input or owned by the peripheral. It only appears once the pin becomes an output, so the bench switches pins into output mode after writing them. A wrong synchronizer depth shows as a read value that is early or late by one edge. The bench samples the read path after exactly one edge and again after two.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      PIN_GP_IN  = 2'd0,
      PIN_GP_OUT = 2'd1,
      PIN_PERIPH = 2'd2
   } pin_mode_e;

   // Ownership dominates; direction only matters for general-purpose pins.
   function automatic pin_mode_e decode_mode(input logic own_bit, input logic dir_bit);
      if (own_bit)
         return PIN_PERIPH;
      else if (dir_bit)
         return PIN_GP_OUT;
      else
         return PIN_GP_IN;
   endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 6,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_async,
   output logic [WIDTH-1:0] lvl_sync
);

   initial begin
      assert (STAGES >= 0 && STAGES <= 4)
         else $error("gpio_in_sync: STAGES must be 0..4");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign lvl_sync = lvl_async;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
            end else begin
               stage_q[0] <= lvl_async;
               for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            end
         end

         assign lvl_sync = stage_q[STAGES-1];

         if (STAGES == 2) begin : g_chk2
            logic [1:0] since_rst_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                since_rst_q <= '0;
               else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
            end

            AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
               (since_rst_q >= 2'd2) |-> (lvl_sync == $past(lvl_async, 2))); // R5
         end
      end
   endgenerate

endmodule

// File: rtl/gpio_pin_route.sv
module gpio_pin_route
   import gpio_port_pkg::*;
(
   input  logic own_bit,
   input  logic dir_bit,
   input  logic data_bit,
   input  logic lvl_bit,
   input  logic per_out_bit,
   input  logic per_oe_bit,
   output logic pad_out_bit,
   output logic pad_oe_bit,
   output logic rd_bit
);

   pin_mode_e mode;

   always_comb begin
      mode = decode_mode(own_bit, dir_bit);
      unique case (mode)
         PIN_PERIPH: begin
            pad_out_bit = per_out_bit;
            pad_oe_bit  = per_oe_bit;
            rd_bit      = 1'b0;
         end
         PIN_GP_OUT: begin
            pad_out_bit = data_bit;
            pad_oe_bit  = 1'b1;
            rd_bit      = data_bit;
         end
         default: begin
            pad_out_bit = data_bit;
            pad_oe_bit  = 1'b0;
            rd_bit      = lvl_bit;
         end
      endcase
   end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
   parameter int                NUM_PINS  = 6,
   parameter int                BUS_W     = 24,
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                soft_rst,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [BUS_W-1:0]    bus_wdata,
   input  logic [NUM_PINS-1:0] data_rd_view,
   output logic [BUS_W-1:0]    bus_rdata,
   output logic [NUM_PINS-1:0] own_q,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] data_q
);

   localparam int                PAD_W     = BUS_W - NUM_PINS;
   localparam logic [ADDR_W-1:0] OWN_ADDR  = BASE_ADDR;
   localparam logic [ADDR_W-1:0] DIR_ADDR  = BASE_ADDR + {{(ADDR_W-1){1'b0}}, 1'b1};
   localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + {{(ADDR_W-2){1'b0}}, 2'b10};

   logic [NUM_PINS-1:0] wr_bits;
   logic                unused_wr_hi;

   assign wr_bits      = bus_wdata[NUM_PINS-1:0];
   assign unused_wr_hi = ^bus_wdata[BUS_W-1:NUM_PINS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q  <= '0;
         dir_q  <= '0;
         data_q <= '0;
      end else if (soft_rst) begin
         own_q  <= '0;
         dir_q  <= '0;
         data_q <= '0;
      end else if (bus_wr) begin
         if (bus_addr == OWN_ADDR)  own_q  <= wr_bits;
         if (bus_addr == DIR_ADDR)  dir_q  <= wr_bits;
         if (bus_addr == DATA_ADDR) data_q <= wr_bits;
      end
   end

   always_comb begin
      if (bus_addr == OWN_ADDR)       bus_rdata = {{PAD_W{1'b0}}, own_q};
      else if (bus_addr == DIR_ADDR)  bus_rdata = {{PAD_W{1'b0}}, dir_q};
      else if (bus_addr == DATA_ADDR) bus_rdata = {{PAD_W{1'b0}}, data_rd_view};
      else                            bus_rdata = '0;
   end

   AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (own_q == '0 && dir_q == '0 && data_q == '0)); // R2

   AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !soft_rst && bus_addr == DATA_ADDR) |=> (data_q == $past(wr_bits))); // R9

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && !soft_rst) |=> ($stable(own_q) && $stable(dir_q) && $stable(data_q))); // R9

endmodule

// File: rtl/shared_gpio_port.sv
module shared_gpio_port #(
   parameter int                NUM_PINS    = 6,
   parameter int                BUS_W       = 24,
   parameter int                ADDR_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h40
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                soft_rst,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [BUS_W-1:0]    bus_wdata,
   output logic [BUS_W-1:0]    bus_rdata,
   input  logic [NUM_PINS-1:0] per_out,
   input  logic [NUM_PINS-1:0] per_oe,
   output logic [NUM_PINS-1:0] per_in,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe
);

   initial begin
      assert (NUM_PINS >= 1 && NUM_PINS < BUS_W)
         else $error("shared_gpio_port: NUM_PINS must be 1..BUS_W-1");
      assert (ADDR_W >= 2)
         else $error("shared_gpio_port: ADDR_W must be at least 2");
   end

   logic [NUM_PINS-1:0] own_q, dir_q, data_q, lvl_sync, rd_view;

   assign per_in = pad_in;

   gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_async (pad_in),
      .lvl_sync  (lvl_sync)
   );

   gpio_port_regs #(
      .NUM_PINS (NUM_PINS), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
   ) regs_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .soft_rst     (soft_rst),
      .bus_addr     (bus_addr),
      .bus_wr       (bus_wr),
      .bus_wdata    (bus_wdata),
      .data_rd_view (rd_view),
      .bus_rdata    (bus_rdata),
      .own_q        (own_q),
      .dir_q        (dir_q),
      .data_q       (data_q)
   );

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         gpio_pin_route route_i (
            .own_bit     (own_q[p]),
            .dir_bit     (dir_q[p]),
            .data_bit    (data_q[p]),
            .lvl_bit     (lvl_sync[p]),
            .per_out_bit (per_out[p]),
            .per_oe_bit  (per_oe[p]),
            .pad_out_bit (pad_out[p]),
            .pad_oe_bit  (pad_oe[p]),
            .rd_bit      (rd_view[p])
         );
      end
   endgenerate

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[BUS_W-1:NUM_PINS] == '0); // R7

   AST_SOFT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (pad_oe == '0)); // R2

   AST_PERIPH_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == BASE_ADDR + {{(ADDR_W-2){1'b0}}, 2'b10}) |-> ((bus_rdata[NUM_PINS-1:0] & own_q) == '0)); // R6

endmodule

// File: tb/shared_gpio_port_tb_top.sv
module shared_gpio_port_tb_top;

   localparam logic [7:0] A_OWN  = 8'h40;
   localparam logic [7:0] A_DIR  = 8'h41;
   localparam logic [7:0] A_DATA = 8'h42;
   localparam logic [7:0] A_NONE = 8'h43;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic [7:0]  bus_addr = A_OWN;
   logic        bus_wr = 1'b0;
   logic [23:0] bus_wdata = '0;
   logic [23:0] bus_rdata;
   logic [5:0]  per_out = '0, per_oe = '0, per_in, pad_in = '0, pad_out, pad_oe;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   shared_gpio_port dut_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .per_out(per_out), .per_oe(per_oe), .per_in(per_in),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [23:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [23:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic t_reset_state;
      logic [23:0] v;
      rd(A_OWN, v); chk("R1 own after reset", v, 24'h0);
      rd(A_DIR, v); chk("R1 dir after reset", v, 24'h0);
      chk("R1 pad_oe after reset", {18'h0, pad_oe}, 24'h0);
   endtask

   task automatic t_gpio_output;
      logic [23:0] v;
      wr(A_DIR, 24'h3F);
      @(negedge clk);
      bus_addr = A_DATA; bus_wdata = 24'h2D; bus_wr = 1'b1;
      #1;
      chk("R9 no effect before edge", {18'h0, pad_out}, 24'h0);
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R4 pad_oe output mode", {18'h0, pad_oe}, 24'h3F);
      chk("R4 pad_out follows data", {18'h0, pad_out}, 24'h2D);
      rd(A_DATA, v); chk("R4 data readback", v, 24'h2D);
      repeat (3) @(negedge clk);
      rd(A_DATA, v); chk("R9 value held without write", v, 24'h2D);
   endtask

   task automatic t_gpio_input;
      logic [23:0] v;
      wr(A_DIR, 24'h0);
      chk("R5 no drive in input mode", {18'h0, pad_oe}, 24'h0);
      @(negedge clk);
      pad_in = 6'h15;
      #1;
      chk("R10 per_in tracks pad", {18'h0, per_in}, 24'h15);
      @(negedge clk);
      rd(A_DATA, v); chk("R5 one edge not yet visible", v, 24'h0);
      @(negedge clk);
      rd(A_DATA, v); chk("R5 level after two edges", v, 24'h15);
   endtask

   task automatic t_peripheral;
      logic [23:0] v;
      wr(A_DIR, 24'h3F);
      per_out = 6'h2A; per_oe = 6'h05;
      wr(A_OWN, 24'h0F);
      chk("R3 pad_oe mix", {18'h0, pad_oe}, 24'h35);
      chk("R3 pad_out mix", {18'h0, pad_out}, 24'h2A);
      per_out = 6'h05; per_oe = 6'h0A;
      #1;
      chk("R3 follows peripheral", {18'h0, pad_out[3:0], pad_oe[3:0]}, 24'h05A);
      rd(A_DATA, v); chk("R6 peripheral bits read 0", v, 24'h20);
   endtask

   task automatic t_reserved;
      logic [23:0] v;
      wr(A_OWN, 24'hFFFFC0);
      rd(A_OWN, v); chk("R7 reserved own bits", v, 24'h0);
      wr(A_DIR, 24'hABCDFF);
      rd(A_DIR, v); chk("R7 reserved dir bits", v, 24'h3F);
   endtask

   task automatic t_hidden_store;
      logic [23:0] v;
      wr(A_DIR, 24'h0);
      pad_in = 6'h0C;
      wr(A_DATA, 24'h33);
      @(negedge clk);
      rd(A_DATA, v); chk("R5 input read shows pad", v, 24'h0C);
      chk("R8 no drive while input", {18'h0, pad_oe}, 24'h0);
      wr(A_DIR, 24'h3F);
      chk("R8 stored bits driven", {18'h0, pad_out}, 24'h33);
   endtask

   task automatic t_unmapped;
      logic [23:0] v;
      wr(A_NONE, 24'h3F);
      rd(A_NONE, v); chk("R9 unmapped reads 0", v, 24'h0);
      rd(A_OWN, v);  chk("R9 unmapped write own intact", v, 24'h0);
      rd(A_DIR, v);  chk("R9 unmapped write dir intact", v, 24'h3F);
      rd(A_DATA, v); chk("R9 unmapped write data intact", v, 24'h33);
   endtask

   task automatic t_soft_reset;
      logic [23:0] v;
      wr(A_OWN, 24'h03);
      @(negedge clk); soft_rst = 1'b1;
      @(negedge clk); soft_rst = 1'b0;
      rd(A_OWN, v); chk("R2 own cleared", v, 24'h0);
      rd(A_DIR, v); chk("R2 dir cleared", v, 24'h0);
      chk("R2 pad_oe cleared", {18'h0, pad_oe}, 24'h0);
      wr(A_DIR, 24'h3F);
      chk("R2 data cleared", {18'h0, pad_out}, 24'h0);
   endtask

   task automatic t_async_reset;
      logic [23:0] v;
      wr(A_DATA, 24'h3C);
      wr(A_OWN, 24'h01);
      @(negedge clk);
      #2 rst_n = 1'b0;
      #1;
      chk("R1 async pad_oe clear", {18'h0, pad_oe}, 24'h0);
      rd(A_OWN, v); chk("R1 async own clear", v, 24'h0);
      @(negedge clk); rst_n = 1'b1;
      wr(A_DIR, 24'h3F);
      chk("R1 async data clear", {18'h0, pad_out}, 24'h0);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog R1..all actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_gpio_output();
      t_gpio_input();
      t_peripheral();
      wr(A_OWN, 24'h0);
      t_reserved();
      t_hidden_store();
      t_unmapped();
      t_soft_reset();
      t_async_reset();
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule